// File: doc/BRIEF.md
# Cache Way Maintenance Sequencer

This block carries out clean, invalidate and clean-plus-invalidate maintenance on a set-associative cache. Software drives it through a small register bus. A write to the way-operation register starts a walk over every set of a group of ways that a mask selects. The walk runs in the background and visits one set/way entry per cycle. A write to the set/way register instead works on a single entry and finishes in the same cycle. A third register provides a sync point, so that software can wait until every eviction the block has issued has been accepted downstream.

The block reads and updates line state through a lookup port on a behavioural tag/state array. Each dirty line that must be written back goes into a one-entry eviction slot with a ready/valid handshake. While a walk runs, a per-way lock vector tells the cache's miss logic which ways must not receive new allocations; hits to those ways are still served. Any write to a maintenance register during a walk is refused with an error response, and reads continue to work normally.

Top module: `way_maint_seq`

## Requirements
- R1: A bus write to address 0 with a nonzero way mask in bits [WAYS-1:0] and a nonzero opcode in bits [17:16] starts a walk over every set of each selected way. The opcodes are 01 clean, 10 invalidate and 11 clean plus invalidate. A write with a zero mask or opcode 00 is ignored.
- R2: Address 0 reads back, in bits [WAYS-1:0], the mask of ways not yet finished. It reads zero once the walk is done. With no eviction stalls the walk takes exactly SETS times the number of selected ways cycles, at one entry per cycle. It visits sets in ascending order and finishes all selected ways of a set, lowest way first, before it moves on.
- R3: During a walk, a write to address 0, 1 or 2 raises busErr for one cycle, in the cycle after the write, and changes no state. A read during a walk returns its data normally.
- R4: allocLock always equals the pending-way readback. A way's bit falls when that way's entry in the last set is processed. Ways outside the mask are never locked, and a locked bit never rises again during a walk.
- R5: Clean sends each valid dirty line to the eviction slot, clears its dirty bit and keeps it valid. Clean lines and invalid lines are left untouched.
- R6: Invalidate clears the valid and dirty bits of every valid line it visits and issues no eviction.
- R7: Clean plus invalidate evicts a line if it is valid and dirty, and clears the valid bit of every valid line it visits.
- R8: A write to address 1 runs an atomic operation on one entry. The set index is in bits [SET_W-1:0], the way in bits [20+WAY_W-1:20] and the opcode in bits [17:16]. The operation changes only that entry, completes at the write edge and leaves address 0 reading zero.
- R9: The eviction slot holds evictValid with a stable evictSet/evictWay until evictReady is seen. A walk stalls on a dirty victim while the slot is occupied, and no eviction is lost.
- R10: A write to address 1 while the eviction slot is occupied gets an error response and changes no entry.
- R11: A write to address 2 makes address 2 read 1 while an eviction accepted before that write is still undrained, and 0 once it drains. A sync write to an empty slot reads 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address (0 way op, 1 set/way op, 2 sync) |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| busErr | output | 1 | Error response, one cycle after a refused write |
| tagSet | output | SET_W | Lookup set index into the tag/state array |
| tagWay | output | WAY_W | Lookup way into the tag/state array |
| tagValid | input | 1 | Valid bit of the addressed entry |
| tagDirty | input | 1 | Dirty bit of the addressed entry |
| tagWrEn | output | 1 | Update the addressed entry at the clock edge |
| tagWrValid | output | 1 | New valid bit |
| tagWrDirty | output | 1 | New dirty bit |
| evictValid | output | 1 | Eviction slot holds a dirty line |
| evictReady | input | 1 | Downstream accepts the eviction |
| evictSet | output | SET_W | Set of the line being evicted |
| evictWay | output | WAY_W | Way of the line being evicted |
| allocLock | output | WAYS | Per-way lock against miss allocation |

## Verification
The bench builds the block with 4 ways and 8 sets, which makes it practical to sweep all 15 way masks under each of the three opcodes. Each walk starts from a line-state pattern computed in the bench, and the final array and the number of evictions are predicted arithmetically. The short walks also allow a cycle-exact check of when each lock bit falls in the last set, along with the eviction stalls caused by a toggling ready. The atomic path, the refused writes and the sync flag are exercised on lines that the bench picks from the same pattern.

// File: rtl/wme_pkg.sv
package wme_pkg;

  // Maintenance opcodes carried in write data bits [OP_LSB+1:OP_LSB]
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_CLEAN = 2'b01,
    OP_INVAL = 2'b10,
    OP_FLUSH = 2'b11
  } maintOp_e;

  localparam int ADDR_W  = 2;
  localparam int OP_LSB  = 16;
  localparam int WAY_LSB = 20;

  localparam logic [ADDR_W-1:0] REG_WAYOP  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_SETWAY = 2'd1;
  localparam logic [ADDR_W-1:0] REG_SYNC   = 2'd2;

  // Control-to-datapath strobes, all single-cycle
  typedef struct packed {
    logic wayStart;   // latch mask/op and begin a walk
    logic swDo;       // atomic set/way operation performed this cycle
    logic syncWr;     // sync register written
    logic step;       // walk entry processed, advance the cursor
    logic evLoad;     // load the looked-up entry into the eviction slot
    logic errPulse;   // refused write, respond with error next cycle
  } strobes_t;

endpackage

// File: rtl/wme_ctrl.sv
module wme_ctrl
  import wme_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 64,
  parameter int DATA_W = 32,
  parameter int SET_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              walkBusy,
  input  logic              evValid,
  input  logic [SET_W-1:0]  curSet,
  input  logic [WAY_W-1:0]  curWay,
  input  logic [1:0]        walkOp,
  input  logic              tagValid,
  input  logic              tagDirty,
  output strobes_t          strb,
  output logic [SET_W-1:0]  tagSet,
  output logic [WAY_W-1:0]  tagWay,
  output logic              tagWrEn,
  output logic              tagWrValid,
  output logic              tagWrDirty
);

  logic [WAYS-1:0] wrMask;
  logic [1:0]      wrOp;
  logic [1:0]      actOp;
  logic            guardedWr;
  logic            needEv;
  logic            doAct;
  logic            unusedWrBits;

  assign wrMask       = busWrData[WAYS-1:0];
  assign wrOp         = busWrData[OP_LSB +: 2];
  assign unusedWrBits = ^busWrData;

  assign guardedWr = busWrEn && ((busAddr == REG_WAYOP) ||
                                 (busAddr == REG_SETWAY) ||
                                 (busAddr == REG_SYNC));

  // The walk owns the lookup port while it runs; otherwise the bus does
  assign actOp  = walkBusy ? walkOp : wrOp;
  assign tagSet = walkBusy ? curSet : busWrData[SET_W-1:0];
  assign tagWay = walkBusy ? curWay : busWrData[WAY_LSB +: WAY_W];

  // A write-back is needed when the opcode has the clean bit and the line is dirty
  assign needEv = tagValid && tagDirty && actOp[0];

  always_comb begin
    strb  = '0;
    doAct = 1'b0;
    if (walkBusy) begin
      strb.errPulse = guardedWr;
      // stall only when a victim must go out and the slot is taken
      if (!(needEv && evValid)) begin
        strb.step = 1'b1;
        doAct     = 1'b1;
      end
    end else if (busWrEn) begin
      case (busAddr)
        REG_WAYOP:  strb.wayStart = (wrMask != '0) && (wrOp != OP_NONE);
        REG_SETWAY: begin
          if (evValid) begin
            strb.errPulse = 1'b1;
          end else if (wrOp != OP_NONE) begin
            strb.swDo = 1'b1;
            doAct     = 1'b1;
          end
        end
        REG_SYNC:   strb.syncWr = 1'b1;
        default:    ;
      endcase
    end
    strb.evLoad = doAct && needEv;
  end

  // New line state per opcode
  always_comb begin
    tagWrEn    = 1'b0;
    tagWrValid = 1'b0;
    tagWrDirty = 1'b0;
    if (doAct) begin
      case (actOp)
        OP_CLEAN: begin
          tagWrEn    = needEv;
          tagWrValid = 1'b1;
        end
        OP_INVAL, OP_FLUSH: tagWrEn = tagValid;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wme_dpath.sv
module wme_dpath
  import wme_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 64,
  parameter int DATA_W = 32,
  parameter int SET_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [SET_W-1:0]  tagSet,
  input  logic [WAY_W-1:0]  tagWay,
  input  logic              evReady,
  output logic              walkBusy,
  output logic [SET_W-1:0]  curSet,
  output logic [WAY_W-1:0]  curWay,
  output logic [1:0]        walkOp,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  output logic              evValid,
  output logic [SET_W-1:0]  evSet,
  output logic [WAY_W-1:0]  evWay,
  output logic [WAYS-1:0]   allocLock
);

  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

  logic [WAYS-1:0] pendMask;
  logic [WAYS-1:0] walkMask;
  logic [WAYS-1:0] higherMask;
  logic [WAYS-1:0] wrMask;
  logic            syncPend;
  logic            lastSet;
  logic            evDrain;
  logic            unusedWrBits;

  function automatic logic [WAY_W-1:0] firstWay(input logic [WAYS-1:0] m);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (m[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  assign wrMask       = busWrData[WAYS-1:0];
  assign unusedWrBits = ^busWrData;
  assign lastSet      = (curSet == LAST_SET);
  assign evDrain      = evValid && evReady;
  assign walkBusy     = |pendMask;
  assign allocLock    = pendMask;

  // Selected ways above the cursor, still to be visited in this set
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      higherMask[i] = walkMask[i] && (i > int'(curWay));
    end
  end

  // Walk cursor and pending mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      walkMask <= '0;
      walkOp   <= OP_NONE;
      curSet   <= '0;
      curWay   <= '0;
    end else if (strb.wayStart) begin
      pendMask <= wrMask;
      walkMask <= wrMask;
      walkOp   <= busWrData[OP_LSB +: 2];
      curSet   <= '0;
      curWay   <= firstWay(wrMask);
    end else if (strb.step) begin
      if (lastSet) pendMask[curWay] <= 1'b0;
      if (|higherMask) begin
        curWay <= firstWay(higherMask);
      end else begin
        curWay <= firstWay(walkMask);
        curSet <= curSet + 1'b1;
      end
    end
  end

  // One-entry eviction slot, sync flag and error response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evValid  <= 1'b0;
      evSet    <= '0;
      evWay    <= '0;
      syncPend <= 1'b0;
      busErr   <= 1'b0;
    end else begin
      if (strb.evLoad) begin
        evValid <= 1'b1;
        evSet   <= tagSet;
        evWay   <= tagWay;
      end else if (evDrain) begin
        evValid <= 1'b0;
      end
      if (strb.syncWr)  syncPend <= evValid && !evReady;
      else if (evDrain) syncPend <= 1'b0;
      busErr <= strb.errPulse;
    end
  end

  // Read side: never refused
  always_comb begin
    busRdData = '0;
    case (busAddr)
      REG_WAYOP: busRdData[WAYS-1:0] = pendMask;
      REG_SYNC:  busRdData[0]        = syncPend;
      default:   ;
    endcase
  end

  assert_ev_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    evValid && !evReady |=> evValid && $stable(evSet) && $stable(evWay));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.evLoad |-> !evValid);

  assert_lock_monotone_R4: assert property (@(posedge clk) disable iff (!rstN)
    walkBusy |=> ((allocLock & ~$past(allocLock)) == '0));

  assert_sync_tracks_slot_R11: assert property (@(posedge clk) disable iff (!rstN)
    syncPend |-> evValid);

endmodule

// File: rtl/way_maint_seq.sv
module way_maint_seq
  import wme_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 64,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  output logic [SET_W-1:0]  tagSet,
  output logic [WAY_W-1:0]  tagWay,
  input  logic              tagValid,
  input  logic              tagDirty,
  output logic              tagWrEn,
  output logic              tagWrValid,
  output logic              tagWrDirty,
  output logic              evictValid,
  input  logic              evictReady,
  output logic [SET_W-1:0]  evictSet,
  output logic [WAY_W-1:0]  evictWay,
  output logic [WAYS-1:0]   allocLock
);

  strobes_t         strb;
  logic             walkBusy;
  logic [SET_W-1:0] curSet;
  logic [WAY_W-1:0] curWay;
  logic [1:0]       walkOp;

  wme_ctrl #(
    .WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) ctrl_i (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .walkBusy  (walkBusy),
    .evValid   (evictValid),
    .curSet    (curSet),
    .curWay    (curWay),
    .walkOp    (walkOp),
    .tagValid  (tagValid),
    .tagDirty  (tagDirty),
    .strb      (strb),
    .tagSet    (tagSet),
    .tagWay    (tagWay),
    .tagWrEn   (tagWrEn),
    .tagWrValid(tagWrValid),
    .tagWrDirty(tagWrDirty)
  );

  wme_dpath #(
    .WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .tagSet   (tagSet),
    .tagWay   (tagWay),
    .evReady  (evictReady),
    .walkBusy (walkBusy),
    .curSet   (curSet),
    .curWay   (curWay),
    .walkOp   (walkOp),
    .busRdData(busRdData),
    .busErr   (busErr),
    .evValid  (evictValid),
    .evSet    (evictSet),
    .evWay    (evictWay),
    .allocLock(allocLock)
  );

  assert_err_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWrEn));

  assert_walk_writes_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|allocLock) && tagWrEn |-> allocLock[tagWay]);

endmodule

// File: tb/way_maint_seq_tb_top.sv
module way_maint_seq_tb_top;

  localparam int WAYS = 4;
  localparam int SETS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busErr;
  logic [2:0]  tagSet;
  logic [1:0]  tagWay;
  logic        tagValid, tagDirty, tagWrEn, tagWrValid, tagWrDirty;
  logic        evictValid, evictReady;
  logic [2:0]  evictSet;
  logic [1:0]  evictWay;
  logic [3:0]  allocLock;

  int checks = 0;
  int failures = 0;
  int evCount = 0;
  int readyMode = 0;
  int tick = 0;
  bit loadReq = 0;
  int loadSeed = 0;
  bit done = 0;

  logic vArr [SETS][WAYS];
  logic dArr [SETS][WAYS];

  always #2 clk = ~clk;

  way_maint_seq #(.WAYS(WAYS), .SETS(SETS), .DATA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .busErr(busErr),
    .tagSet(tagSet), .tagWay(tagWay), .tagValid(tagValid), .tagDirty(tagDirty),
    .tagWrEn(tagWrEn), .tagWrValid(tagWrValid), .tagWrDirty(tagWrDirty),
    .evictValid(evictValid), .evictReady(evictReady), .evictSet(evictSet),
    .evictWay(evictWay), .allocLock(allocLock)
  );

  function automatic bit patV(int seed, int s, int w);
    return ((s * 3 + w + seed) % 3) != 0;
  endfunction

  function automatic bit patD(int seed, int s, int w);
    return patV(seed, s, w) && (((s + 2 * w + seed) % 2) == 0);
  endfunction

  // Behavioural tag/state array and eviction sink
  assign tagValid   = vArr[tagSet][tagWay];
  assign tagDirty   = dArr[tagSet][tagWay];
  assign evictReady = (readyMode == 0) || (readyMode == 1 && tick[0]);

  always @(posedge clk) begin
    tick <= tick + 1;
    if (evictValid && evictReady) evCount <= evCount + 1;
    if (loadReq) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vArr[s][w] <= patV(loadSeed, s, w);
          dArr[s][w] <= patD(loadSeed, s, w);
        end
    end else if (tagWrEn) begin
      vArr[tagSet][tagWay] <= tagWrValid;
      dArr[tagSet][tagWay] <= tagWrDirty;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1 err = busErr;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic loadArr(input int seed);
    @(negedge clk);
    loadSeed = seed; loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
  endtask

  function automatic logic [31:0] swWord(int s, int w, int op);
    return (32'(w) << 20) | (32'(op) << 16) | 32'(s);
  endfunction

  function automatic int popc(logic [3:0] m);
    return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
  endfunction

  // Lock expected after k walk steps with no stalls: a way drops at its step in the last set
  function automatic logic [3:0] expLockAt(logic [3:0] m, int k);
    logic [3:0] r;
    int j;
    r = m; j = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (m[w]) begin
        if ((SETS - 1) * popc(m) + j + 1 <= k) r[w] = 1'b0;
        j++;
      end
    end
    return r;
  endfunction

  task automatic drainSlot();
    for (int n = 0; n < 100 && evictValid; n++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic countMismatch(input int seed, input logic [3:0] m, input int op, output int mism);
    bit ev, ed;
    mism = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        ev = patV(seed, s, w); ed = patD(seed, s, w);
        if (m[w]) begin
          if (op == 1) ed = 1'b0;
          else begin ev = 1'b0; ed = 1'b0; end
        end
        if (vArr[s][w] !== ev || dArr[s][w] !== ed) mism++;
      end
  endtask

  task automatic runWalk(input int op, input logic [3:0] m, input int seed, input int rmode);
    logic err;
    int k, startEv, expEv, mism;
    bit lockOk, exactOk;
    logic [3:0] prevLock;
    readyMode = rmode;
    loadArr(seed);
    expEv = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (m[w] && (op & 1) && patD(seed, s, w)) expEv++;
    startEv = evCount;
    busWrite(2'd0, (32'(op) << 16) | 32'(m), err);
    check(err == 1'b0, "R1 walk start accepted without error", int'(err), 0);
    busAddr = 2'd0;
    #1;
    k = 0; lockOk = 1; exactOk = 1; prevLock = m;
    while (busRdData[3:0] != 4'h0 && k < 2000) begin
      if (busRdData[3:0] !== allocLock) lockOk = 0;
      if ((allocLock & ~m) != 4'h0) lockOk = 0;
      if ((allocLock & ~prevLock) != 4'h0) lockOk = 0;
      if (op == 2 && allocLock !== expLockAt(m, k)) exactOk = 0;
      prevLock = allocLock;
      k++;
      @(negedge clk); #1;
    end
    check(lockOk, "R4 lock equals pending readback, within mask, falling only", int'(lockOk), 1);
    check(allocLock == 4'h0, "R2 readback and lock zero at completion", int'(allocLock), 0);
    if (op == 2) begin
      check(k == SETS * popc(m), "R2 walk length one entry per cycle", k, SETS * popc(m));
      check(exactOk, "R4 lock bit falls at last-set step", int'(exactOk), 1);
    end else begin
      check(k >= SETS * popc(m), "R2 walk covers every selected entry", k, SETS * popc(m));
    end
    drainSlot();
    check(evCount - startEv == expEv, (op == 1) ? "R5 clean eviction count" :
          (op == 2) ? "R6 invalidate issues no eviction" : "R7 flush eviction count",
          evCount - startEv, expEv);
    countMismatch(seed, m, op, mism);
    check(mism == 0, (op == 1) ? "R5 clean final line state" :
          (op == 2) ? "R6 invalidate final line state" : "R7 flush final line state", mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic err;
    int mism, startEv, ds, dw, cs, cw, seed;
    repeat (3) @(negedge clk);
    loadArr(1);
    rstN = 1'b1;

    // Reset state
    readReg(2'd0, rd);
    check(rd == 32'h0, "R2 reset readback zero", int'(rd), 0);
    check(allocLock == 4'h0, "R4 reset lock clear", int'(allocLock), 0);
    check(evictValid == 1'b0, "R9 reset slot empty", int'(evictValid), 0);
    readReg(2'd2, rd);
    check(rd == 32'h0, "R11 reset sync reads zero", int'(rd), 0);

    // Ignored way-op writes
    loadArr(2);
    busWrite(2'd0, 32'h0001_0000, err);
    readReg(2'd0, rd);
    check(rd == 32'h0 && allocLock == 4'h0, "R1 zero mask ignored", int'(rd), 0);
    busWrite(2'd0, 32'h0000_000F, err);
    readReg(2'd0, rd);
    check(rd == 32'h0 && allocLock == 4'h0, "R1 opcode 00 ignored", int'(rd), 0);
    countMismatch(2, 4'h0, 1, mism);
    check(mism == 0, "R1 ignored writes leave lines unchanged", mism, 0);

    // Sweep of every mask under every opcode
    for (int op = 1; op <= 3; op++)
      for (int m = 1; m < 16; m++)
        runWalk(op, 4'(m), op * 7 + m, m % 2);

    // Guarded registers during a walk
    seed = 4;
    readyMode = 0;
    loadArr(seed);
    cs = -1; cw = -1;
    for (int s = 0; s < SETS; s++)
      if (cs < 0 && patD(seed, s, 3)) begin cs = s; cw = 3; end
    startEv = evCount;
    busWrite(2'd0, 32'h0002_0003, err);
    busWrite(2'd1, swWord(cs, cw, 1), err);
    check(err == 1'b1, "R3 set/way write refused during walk", int'(err), 1);
    busWrite(2'd0, 32'h0001_0001, err);
    check(err == 1'b1, "R3 way-op write refused during walk", int'(err), 1);
    busWrite(2'd2, 32'h0, err);
    check(err == 1'b1, "R3 sync write refused during walk", int'(err), 1);
    readReg(2'd0, rd);
    check(rd[3:0] == 4'h3, "R3 read during walk returns pending mask", int'(rd), 3);
    #1 check(busErr == 1'b0, "R3 read gives no error", int'(busErr), 0);
    for (int n = 0; n < 200 && allocLock != 4'h0; n++) begin @(negedge clk); #1; end
    drainSlot();
    countMismatch(seed, 4'h3, 2, mism);
    check(mism == 0, "R3 refused writes changed no line", mism, 0);
    check(evCount - startEv == 0, "R3 refused set/way issued no eviction", evCount - startEv, 0);
    readReg(2'd2, rd);
    check(rd == 32'h0, "R3 refused sync left flag clear", int'(rd), 0);

    // Atomic set/way, slot occupancy and sync
    seed = 5;
    readyMode = 2;
    loadArr(seed);
    ds = -1; dw = -1; cs = -1; cw = -1;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        if (ds < 0 && patD(seed, s, w)) begin ds = s; dw = w; end
      end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (cs < 0 && patV(seed, s, w) && !(s == ds && w == dw)) begin cs = s; cw = w; end
    busWrite(2'd1, swWord(ds, dw, 1), err);
    check(err == 1'b0, "R8 set/way clean accepted", int'(err), 0);
    check(busRdData == 32'h0 && allocLock == 4'h0, "R8 atomic op leaves no busy state", int'(allocLock), 0);
    check(vArr[ds][dw] == 1'b1 && dArr[ds][dw] == 1'b0, "R8 set/way clean updates entry",
          int'({vArr[ds][dw], dArr[ds][dw]}), 2);
    check(evictValid && int'(evictSet) == ds && int'(evictWay) == dw, "R9 slot holds the victim",
          int'({evictSet, evictWay}), ds * 4 + dw);
    countMismatch(seed, 4'h0, 1, mism);
    check(mism == 1, "R8 only one entry changed", mism, 1);
    repeat (3) @(negedge clk);
    #1 check(evictValid && int'(evictSet) == ds, "R9 slot held until ready", int'(evictValid), 1);
    busWrite(2'd1, swWord(cs, cw, 2), err);
    check(err == 1'b1, "R10 set/way refused while slot occupied", int'(err), 1);
    check(vArr[cs][cw] == 1'b1, "R10 refused set/way left entry valid", int'(vArr[cs][cw]), 1);
    busWrite(2'd2, 32'h0, err);
    check(err == 1'b0, "R11 sync write accepted", int'(err), 0);
    readReg(2'd2, rd);
    check(rd == 32'h1, "R11 sync reads one while slot undrained", int'(rd), 1);
    startEv = evCount;
    readyMode = 0;
    repeat (2) @(negedge clk);
    readReg(2'd2, rd);
    check(rd == 32'h0 && !evictValid, "R11 sync reads zero after drain", int'(rd), 0);
    check(evCount - startEv == 1, "R9 victim accepted exactly once", evCount - startEv, 1);
    busWrite(2'd2, 32'h0, err);
    readReg(2'd2, rd);
    check(rd == 32'h0, "R11 sync with empty slot reads zero", int'(rd), 0);

    // Atomic invalidate and flush
    startEv = evCount;
    busWrite(2'd1, swWord(cs, cw, 2), err);
    check(vArr[cs][cw] == 1'b0 && dArr[cs][cw] == 1'b0, "R8 set/way invalidate clears entry",
          int'(vArr[cs][cw]), 0);
    drainSlot();
    check(evCount == startEv, "R6 set/way invalidate no eviction", evCount - startEv, 0);
    loadArr(seed);
    busWrite(2'd1, swWord(ds, dw, 3), err);
    check(vArr[ds][dw] == 1'b0, "R7 set/way flush clears valid", int'(vArr[ds][dw]), 0);
    drainSlot();
    check(evCount - startEv == 1, "R7 set/way flush evicts dirty line", evCount - startEv, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule